// File: doc/BRIEF.md
# Cache-Line Access Checker for Global Shared Memory

This block watches the application processor's memory bus and judges every transaction whose address falls inside one aligned window of physical memory that is set aside for global shared data. Pages of that window are backed by local memory, but the right to touch the data is tracked one cache line at a time. For each snooped transaction inside the window, the block combines the operation type (read or write) with the two-bit state of the addressed line and registers one of three verdicts: let it complete against local memory, let it complete but also report it, or force a bus retry and report it. Traffic outside the window is always allowed and never reported.

Reported transactions are placed in a small capture queue that the service processor drains one entry at a time. The service processor is the only agent that can change a line's state, through a dedicated write port. A line that is not usable therefore keeps getting retried until the service processor rewrites its state. A retried request that is already waiting in the queue is not queued a second time, and when the queue is full any transaction that would need reporting is retried without being queued, so that no report is lost while the bus goes on.

Top module: `line_access_checker`

## Requirements
- R1: A snooped address outside the window (base `WIN_BASE`, size `LINES*LINE_BYTES` bytes) gives dec_in_window=0 and dec_action=00 (proceed), and adds nothing to the capture queue.
- R2: The verdict for a transaction sampled with snp_valid=1 on a clock edge appears on dec_valid/dec_action/dec_in_window after exactly that one edge; dec_valid is 0 in every cycle that follows an edge where snp_valid was 0, and back-to-back transactions give back-to-back verdicts.
- R3: Line states are coded 00 invalid, 01 read-only, 10 read-write, 11 read-write-notify; verdicts are coded 00 proceed, 01 proceed-and-report, 10 retry-and-report. Invalid gives 10 for any access; read-only gives 00 for a read and 10 for a write; read-write gives 00; read-write-notify gives 01.
- R4: After reset every line is invalid, the capture queue is empty (cq_valid=0) and dec_valid is 0.
- R5: A state write on sp_set_en takes effect for snoops sampled on later edges; a snoop sampled on the same edge as the write sees the old state.
- R6: Snooped traffic never changes a line's state: repeated accesses to an unusable line keep getting verdict 10 until the service processor rewrites the state.
- R7: Each reported transaction is queued as its line index (address bits above the line offset, relative to the window base), its write flag, and a retry flag that is 1 for verdict 10 and 0 for verdict 01; entries leave in arrival order.
- R8: A retry-and-report transaction is not queued when an entry with the same line, same write flag and retry flag 1 is already in the queue; proceed-and-report transactions are always queued.
- R9: When the queue holds `QUEUE_DEPTH` entries, any in-window transaction that needs reporting gets verdict 10 and is not queued.
- R10: cq_pop while cq_valid=1 removes the head entry on that edge; cq_valid is 0 when the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snp_valid | input | 1 | Bus address phase present |
| snp_addr | input | AW | Physical address of the transaction |
| snp_write | input | 1 | 1 for write, 0 for read |
| dec_valid | output | 1 | Registered verdict present |
| dec_in_window | output | 1 | Transaction was inside the shared window |
| dec_action | output | 2 | Verdict: 00 proceed, 01 proceed-and-report, 10 retry-and-report |
| sp_set_en | input | 1 | Service processor writes a line state |
| sp_set_line | input | log2(LINES) | Line index to write |
| sp_set_state | input | 2 | New line state |
| cq_pop | input | 1 | Service processor removes the head entry |
| cq_valid | output | 1 | Capture queue not empty |
| cq_line | output | log2(LINES) | Head entry line index |
| cq_write | output | 1 | Head entry write flag |
| cq_retry | output | 1 | Head entry was retried |

## Verification
The verdict path is driven with reads and writes against each of the four line states, so that a wrong entry in the state-by-operation table shows up as a mismatched verdict, and with addresses just below, at the top of and just past the window to separate the window compare from the line-index slice. Repeated retries of one line and a mix of read and write retries to the same line tell apart the duplicate filter from plain enqueueing, while repeated notify reads confirm that allowed reports are never filtered. A snoop on the same edge as a state write, and a burst that fills the queue followed by further reportable accesses, tell apart old-versus-new state ordering and the full-queue fallback from normal reporting.

// File: rtl/lac_pkg.sv
package lac_pkg;
   typedef enum logic [1:0] {
      LS_INVALID   = 2'b00,
      LS_READONLY  = 2'b01,
      LS_READWRITE = 2'b10,
      LS_RW_NOTIFY = 2'b11
   } line_state_e;

   typedef enum logic [1:0] {
      ACT_PROCEED     = 2'b00,
      ACT_PROCEED_FWD = 2'b01,
      ACT_RETRY_FWD   = 2'b10
   } bus_action_e;
endpackage

// File: rtl/lac_state_table.sv
module lac_state_table
   import lac_pkg::*;
#(
   parameter int LINES = 64,
   localparam int LW = $clog2(LINES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [LW-1:0] wr_idx,
   input  logic [1:0]    wr_state,
   input  logic [LW-1:0] rd_idx,
   output line_state_e   rd_state
);
   line_state_e st_q [LINES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < LINES; i++) st_q[i] <= LS_INVALID;
      end else if (wr_en) begin
         st_q[wr_idx] <= line_state_e'(wr_state);
      end
   end

   assign rd_state = st_q[rd_idx];
endmodule

// File: rtl/lac_decide.sv
module lac_decide
   import lac_pkg::*;
(
   input  line_state_e state,
   input  logic        is_write,
   output bus_action_e action
);
   always_comb begin
      unique case (state)
         LS_INVALID:   action = ACT_RETRY_FWD;
         LS_READONLY:  action = is_write ? ACT_RETRY_FWD : ACT_PROCEED;
         LS_READWRITE: action = ACT_PROCEED;
         LS_RW_NOTIFY: action = ACT_PROCEED_FWD;
         default:      action = ACT_RETRY_FWD;
      endcase
   end
endmodule

// File: rtl/lac_capture_q.sv
module lac_capture_q #(
   parameter int DEPTH = 4,
   parameter int LW    = 6,
   localparam int PW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [LW-1:0] push_line,
   input  logic          push_write,
   input  logic          push_retry,
   input  logic          pop,
   output logic          q_valid,
   output logic [LW-1:0] q_line,
   output logic          q_write,
   output logic          q_retry,
   output logic          full,
   output logic [CW-1:0] count,
   input  logic [LW-1:0] qry_line,
   input  logic          qry_write,
   output logic          qry_hit
);
   logic [LW-1:0] line_q [DEPTH];
   logic          wr_q   [DEPTH];
   logic          rt_q   [DEPTH];
   logic [PW-1:0] rd_ptr, wr_ptr;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;
   logic [DEPTH-1:0] hit_vec;

   assign full    = (cnt == CW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && (cnt != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + PW'(1);
         if (do_pop)  rd_ptr <= rd_ptr + PW'(1);
         if (do_push && !do_pop)      cnt <= cnt + CW'(1);
         else if (do_pop && !do_push) cnt <= cnt - CW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) begin
         line_q[wr_ptr] <= push_line;
         wr_q[wr_ptr]   <= push_write;
         rt_q[wr_ptr]   <= push_retry;
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [PW-1:0] age;
      logic          live;
      assign age        = PW'(i) - rd_ptr;
      assign live       = CW'(age) < cnt;
      assign hit_vec[i] = live && rt_q[i] && (wr_q[i] == qry_write)
                          && (line_q[i] == qry_line);
   end

   assign qry_hit = |hit_vec;
   assign q_valid = (cnt != '0);
   assign q_line  = line_q[rd_ptr];
   assign q_write = wr_q[rd_ptr];
   assign q_retry = rt_q[rd_ptr];
   assign count   = cnt;
endmodule

// File: rtl/line_access_checker.sv
module line_access_checker
   import lac_pkg::*;
#(
   parameter int            AW          = 32,
   parameter int            LINE_BYTES  = 32,
   parameter int            LINES       = 64,
   parameter int            QUEUE_DEPTH = 4,
   parameter bit            DEDUP_EN    = 1'b1,
   parameter logic [31:0]   WIN_BASE    = 32'h0001_0000,
   localparam int LOFF = $clog2(LINE_BYTES),
   localparam int LW   = $clog2(LINES),
   localparam int TAGL = LOFF + LW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          snp_valid,
   input  logic [AW-1:0] snp_addr,
   input  logic          snp_write,
   output logic          dec_valid,
   output logic          dec_in_window,
   output logic [1:0]    dec_action,
   input  logic          sp_set_en,
   input  logic [LW-1:0] sp_set_line,
   input  logic [1:0]    sp_set_state,
   input  logic          cq_pop,
   output logic          cq_valid,
   output logic [LW-1:0] cq_line,
   output logic          cq_write,
   output logic          cq_retry
);
   localparam int CW = $clog2(QUEUE_DEPTH + 1);
   localparam logic [AW-1:0] BASE = AW'(WIN_BASE);

   if ((1 << LOFF) != LINE_BYTES || (1 << LW) != LINES) begin : g_bad_pow2
      $error("LINE_BYTES and LINES must be powers of two");
   end
   if (QUEUE_DEPTH < 2 || (1 << $clog2(QUEUE_DEPTH)) != QUEUE_DEPTH) begin : g_bad_depth
      $error("QUEUE_DEPTH must be a power of two of at least 2");
   end
   if (TAGL >= AW || AW > 32) begin : g_bad_width
      $error("window must be smaller than the address space");
   end
   if (BASE[TAGL-1:0] != '0) begin : g_bad_base
      $error("WIN_BASE must be aligned to the window size");
   end

   logic          in_win;
   logic [LW-1:0] line_idx;
   line_state_e   cur_state;
   bus_action_e   base_act, fin_act;
   logic          q_full, q_hit, pending, needs_fwd, push;
   logic [CW-1:0] q_count;

   assign in_win   = (snp_addr[AW-1:TAGL] == BASE[AW-1:TAGL]);
   assign line_idx = snp_addr[TAGL-1:LOFF];

   lac_state_table #(.LINES(LINES)) u_table (
      .clk(clk), .rst_n(rst_n),
      .wr_en(sp_set_en), .wr_idx(sp_set_line), .wr_state(sp_set_state),
      .rd_idx(line_idx), .rd_state(cur_state)
   );

   lac_decide u_decide (
      .state(cur_state), .is_write(snp_write), .action(base_act)
   );

   lac_capture_q #(.DEPTH(QUEUE_DEPTH), .LW(LW)) u_cq (
      .clk(clk), .rst_n(rst_n),
      .push(push), .push_line(line_idx), .push_write(snp_write),
      .push_retry(base_act == ACT_RETRY_FWD),
      .pop(cq_pop),
      .q_valid(cq_valid), .q_line(cq_line), .q_write(cq_write), .q_retry(cq_retry),
      .full(q_full), .count(q_count),
      .qry_line(line_idx), .qry_write(snp_write), .qry_hit(q_hit)
   );

   if (DEDUP_EN) begin : g_dedup
      assign pending = q_hit && (base_act == ACT_RETRY_FWD);
   end else begin : g_nodedup
      assign pending = 1'b0;
   end

   assign needs_fwd = in_win && (base_act != ACT_PROCEED);

   always_comb begin
      if (!in_win)                fin_act = ACT_PROCEED;
      else if (needs_fwd && q_full) fin_act = ACT_RETRY_FWD;
      else                        fin_act = base_act;
   end

   assign push = snp_valid && needs_fwd && !q_full && !pending;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_valid     <= 1'b0;
         dec_in_window <= 1'b0;
         dec_action    <= ACT_PROCEED;
      end else begin
         dec_valid     <= snp_valid;
         dec_in_window <= snp_valid && in_win;
         dec_action    <= snp_valid ? fin_act : ACT_PROCEED;
      end
   end
endmodule

// File: rtl/line_access_checker_sva.sv
module line_access_checker_sva #(
   parameter int DEPTH = 4,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          snp_valid,
   input logic          in_win,
   input logic          push,
   input logic          q_full,
   input logic [CW-1:0] q_count,
   input logic          cq_pop,
   input logic          cq_valid,
   input logic          dec_valid,
   input logic          dec_in_window,
   input logic [1:0]    dec_action
);
   // R2: verdict follows the address phase by one edge
   a_r2_verdict_follows: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid |=> dec_valid);
   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !snp_valid |=> !dec_valid);
   // R1: outside traffic always proceeds
   a_r1_outside_proceeds: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !dec_in_window) |-> (dec_action == 2'b00));
   // R3: only three verdict codes exist
   a_r3_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> (dec_action != 2'b11));
   // R9: a full queue never lets a reportable access proceed
   a_r9_full_retries: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && in_win && q_full) |=> (dec_action != 2'b01));
   a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      q_count <= CW'(DEPTH));
   // R10: a pop without a push shrinks the queue by one
   a_r10_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
      (cq_pop && cq_valid && !push) |=> (q_count == $past(q_count) - CW'(1)));
   // R10: empty flag tracks the count
   a_r10_valid_matches: assert property (@(posedge clk) disable iff (!rst_n)
      cq_valid == (q_count != '0));
endmodule

bind line_access_checker line_access_checker_sva #(.DEPTH(QUEUE_DEPTH)) u_sva (
   .clk(clk), .rst_n(rst_n), .snp_valid(snp_valid), .in_win(in_win),
   .push(push), .q_full(q_full), .q_count(q_count), .cq_pop(cq_pop),
   .cq_valid(cq_valid), .dec_valid(dec_valid), .dec_in_window(dec_in_window),
   .dec_action(dec_action)
);

// File: tb/sim_line_access_checker.sv
`timescale 1ns/1ps
module sim_line_access_checker;
   localparam int AW = 32;
   localparam int LW = 6;
   localparam logic [31:0] BASE = 32'h0001_0000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          snp_valid = 1'b0;
   logic [AW-1:0] snp_addr = '0;
   logic          snp_write = 1'b0;
   logic          dec_valid, dec_in_window;
   logic [1:0]    dec_action;
   logic          sp_set_en = 1'b0;
   logic [LW-1:0] sp_set_line = '0;
   logic [1:0]    sp_set_state = '0;
   logic          cq_pop = 1'b0;
   logic          cq_valid, cq_write, cq_retry;
   logic [LW-1:0] cq_line;

   int compared = 0;
   int mismatched = 0;
   bit finished = 1'b0;

   logic [2:0] exp_q [$];
   string      tag_q [$];

   always #2 clk = ~clk;

   line_access_checker u0 (
      .clk(clk), .rst_n(rst_n), .snp_valid(snp_valid), .snp_addr(snp_addr),
      .snp_write(snp_write), .dec_valid(dec_valid), .dec_in_window(dec_in_window),
      .dec_action(dec_action), .sp_set_en(sp_set_en), .sp_set_line(sp_set_line),
      .sp_set_state(sp_set_state), .cq_pop(cq_pop), .cq_valid(cq_valid),
      .cq_line(cq_line), .cq_write(cq_write), .cq_retry(cq_retry)
   );

   function automatic logic [31:0] la(input int line);
      return BASE + 32'(line * 32) + 32'd4;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // Monitor: pops expected verdicts as the design produces them
   always @(negedge clk) begin
      if (rst_n && dec_valid) begin
         if (exp_q.size() == 0) begin
            check("R2 unexpected verdict", 32'd1, 32'd0);
         end else begin
            logic [2:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, {29'd0, dec_in_window, dec_action}, {29'd0, e});
         end
      end
   end

   // Driver: one snoop, expected verdict into the scoreboard
   task automatic snoop(input logic [31:0] a, input logic w, input logic inw,
                        input logic [1:0] act, input string tag);
      @(negedge clk);
      snp_valid = 1'b1; snp_addr = a; snp_write = w;
      exp_q.push_back({inw, act});
      tag_q.push_back(tag);
      @(negedge clk);
      snp_valid = 1'b0;
   endtask

   task automatic set_line(input int line, input logic [1:0] st);
      @(negedge clk);
      sp_set_en = 1'b1; sp_set_line = LW'(line); sp_set_state = st;
      @(negedge clk);
      sp_set_en = 1'b0;
   endtask

   task automatic expect_entry(input int line, input logic w, input logic r, input string tag);
      @(negedge clk);
      check({tag, " valid"}, {31'd0, cq_valid}, 32'd1);
      check({tag, " entry"}, {24'd0, cq_line, cq_write, cq_retry}, {24'd0, LW'(line), w, r});
      cq_pop = 1'b1;
      @(negedge clk);
      cq_pop = 1'b0;
   endtask

   task automatic expect_empty(input string tag);
      @(negedge clk);
      check(tag, {31'd0, cq_valid}, 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R4 dec_valid at reset", {31'd0, dec_valid}, 32'd0);
      check("R4 queue empty at reset", {31'd0, cq_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: outside the window, including both edges
      snoop(32'h0000_1000, 1'b0, 1'b0, 2'b00, "R1 outside read");
      snoop(32'h0000_1000, 1'b1, 1'b0, 2'b00, "R1 outside write");
      snoop(BASE - 32'd1, 1'b1, 1'b0, 2'b00, "R1 just below window");
      snoop(BASE + 32'd2048, 1'b0, 1'b0, 2'b00, "R1 just past window");
      expect_empty("R1 nothing queued");

      // R4/R3/R6/R8: invalid line retries, duplicates filtered
      snoop(la(3), 1'b0, 1'b1, 2'b10, "R3 invalid read");
      snoop(la(3), 1'b0, 1'b1, 2'b10, "R6 repeat retry");
      snoop(la(3), 1'b0, 1'b1, 2'b10, "R8 duplicate retry");
      snoop(la(3), 1'b1, 1'b1, 2'b10, "R3 invalid write");
      snoop(BASE + 32'd2047, 1'b0, 1'b1, 2'b10, "R1 top line in window");
      expect_entry(3, 1'b0, 1'b1, "R8 first read retry");
      expect_entry(3, 1'b1, 1'b1, "R7 write retry");
      expect_entry(63, 1'b0, 1'b1, "R7 top line index");
      expect_empty("R8 no duplicate queued");

      // R3 read-only
      set_line(3, 2'b01);
      snoop(la(3), 1'b0, 1'b1, 2'b00, "R3 read-only read");
      snoop(la(3), 1'b1, 1'b1, 2'b10, "R3 read-only write");
      expect_entry(3, 1'b1, 1'b1, "R7 read-only write report");
      expect_empty("R3 read-only read not queued");

      // R3 read-write
      set_line(5, 2'b10);
      snoop(la(5), 1'b0, 1'b1, 2'b00, "R3 read-write read");
      snoop(la(5), 1'b1, 1'b1, 2'b00, "R3 read-write write");
      expect_empty("R3 read-write not queued");

      // R3/R8 notify: proceed and report, never filtered
      set_line(7, 2'b11);
      snoop(la(7), 1'b0, 1'b1, 2'b01, "R3 notify read");
      snoop(la(7), 1'b0, 1'b1, 2'b01, "R8 notify read again");
      expect_entry(7, 1'b0, 1'b0, "R7 notify entry 1");
      expect_entry(7, 1'b0, 1'b0, "R8 notify entry 2");
      expect_empty("R10 drained");

      // R5: same-edge write sees old state
      @(negedge clk);
      sp_set_en = 1'b1; sp_set_line = LW'(9); sp_set_state = 2'b10;
      snp_valid = 1'b1; snp_addr = la(9); snp_write = 1'b0;
      exp_q.push_back({1'b1, 2'b10}); tag_q.push_back("R5 same edge old state");
      @(negedge clk);
      sp_set_en = 1'b0; snp_valid = 1'b0;
      snoop(la(9), 1'b0, 1'b1, 2'b00, "R5 later sees new state");
      expect_entry(9, 1'b0, 1'b1, "R5 old-state report");
      expect_empty("R5 drained");

      // R2: back-to-back verdicts
      @(negedge clk);
      snp_valid = 1'b1; snp_addr = la(5); snp_write = 1'b1;
      exp_q.push_back({1'b1, 2'b00}); tag_q.push_back("R2 back-to-back 1");
      @(negedge clk);
      snp_addr = 32'h0000_0040;
      exp_q.push_back({1'b0, 2'b00}); tag_q.push_back("R2 back-to-back 2");
      @(negedge clk);
      snp_addr = la(3); snp_write = 1'b0;
      exp_q.push_back({1'b1, 2'b00}); tag_q.push_back("R2 back-to-back 3");
      @(negedge clk);
      snp_valid = 1'b0;

      // R9: fill queue, then reportable accesses retry without queueing
      for (int i = 10; i < 14; i++) snoop(la(i), 1'b0, 1'b1, 2'b10, "R9 fill");
      snoop(la(7), 1'b0, 1'b1, 2'b10, "R9 notify becomes retry");
      snoop(la(14), 1'b1, 1'b1, 2'b10, "R9 invalid when full");
      snoop(la(5), 1'b0, 1'b1, 2'b00, "R9 legal access still proceeds");
      for (int i = 10; i < 14; i++) expect_entry(i, 1'b0, 1'b1, "R9 order kept");
      expect_empty("R9 nothing queued while full");

      repeat (3) @(negedge clk);
      check("R2 all verdicts seen", 32'(exp_q.size()), 32'd0);
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule